// File: doc/BRIEF.md
# Generic Command Packet Builder for a Display Serial Link

The block sits between a register-programmed host and the byte stream of a display serial link. The host first writes the payload of a command, one 32-bit word at a time, into a payload FIFO. It then writes a 24-bit header word into a command FIFO, and that write starts transmission. The block takes headers in arrival order. For each one it emits either a four-byte short packet or a long packet, which is a four-byte header followed by the payload bytes the header announces.

The header word's data type selects the packet kind. For a long type, the two upper header bytes are read as a byte count and the payload is drawn from the payload FIFO, lowest byte of each word first. For a short type, the same two bytes are sent as the packet's two parameter bytes and the payload FIFO is left alone. A long header whose count exceeds the bytes waiting in the payload FIFO is discarded, and an error pulse is raised. Both FIFOs report empty and full to the host. The fourth header byte is a check-byte placeholder.

Top module: `dsi_cmd_pkt_builder`

## Requirements
- R1: The header input word holds the data type in bits 5:0, the virtual channel in bits 7:6, a low byte in bits 15:8 and a high byte in bits 23:16. The first emitted byte is {channel, type}, followed by the low byte, the high byte and the check byte.
- R2: The check byte is the bitwise XOR of the three header bytes that precede it.
- R3: A data type with bit 3 clear is a short packet. Exactly four bytes are sent, the two upper header bytes are sent as parameters, and no payload word is consumed.
- R4: A data type with bit 3 set is a long packet. Bits 23:8 give the byte count N. The four header bytes are followed by N payload bytes, taken little-endian from successive payload words. A partly used last word is removed from the FIFO, and its unused bytes are discarded.
- R5: A long packet with N = 0 sends only its four header bytes and consumes no payload.
- R6: If a long header arrives with N greater than four times the number of words held in the payload FIFO, nothing is sent for it, `underflow_err` is high for one cycle, the header is dropped and the payload words stay queued.
- R7: `cmd_empty` and `pld_empty` are high when the matching FIFO holds nothing. `cmd_full` and `pld_full` are high at 4 and 16 entries respectively. A write to a full FIFO is ignored.
- R8: `tx_valid` stays high for every byte of a packet without a gap. `tx_first` marks the first byte and `tx_last` marks the final byte.
- R9: The first byte of a packet appears in the second cycle after the clock edge that stores its header. Queued headers are sent in order, with one idle cycle between packets.
- R10: After reset no byte is valid, `underflow_err` is low, both FIFOs are empty and neither is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pld_wr_en | input | 1 | Push a payload word |
| pld_wr_data | input | 32 | Payload word, byte 0 in bits 7:0 |
| hdr_wr_en | input | 1 | Push a header word, which requests transmission |
| hdr_wr_data | input | 24 | Header word: type, channel, low byte, high byte |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Final byte of a packet |
| cmd_empty | output | 1 | Command FIFO is empty |
| cmd_full | output | 1 | Command FIFO is full |
| pld_empty | output | 1 | Payload FIFO is empty |
| pld_full | output | 1 | Payload FIFO is full |
| underflow_err | output | 1 | One-cycle pulse when a long header is dropped |

## Verification
The assertions rely on the host honouring the ordering rule: a header is written only after all of its payload words are in the FIFO, and the count it carries never exceeds what the payload FIFO can hold. The stimulus follows this rule. Each vector pushes its payload words a cycle at a time before its header, and the largest count used is 64 bytes. The single overflow case writes a seventeenth word on purpose, and the bench's own model drops that word, as R7 requires.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;

    localparam int WORD_W = 32;
    localparam int HDR_W  = 24;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PLD  = 2'd2
    } pkt_state_e;

    // Long-packet data types carry bit 3 set.
    function automatic logic type_is_long(input logic [5:0] dtype);
        return dtype[3];
    endfunction

    // Placeholder check byte over the three header bytes.
    function automatic logic [7:0] check_byte(input logic [7:0] b0,
                                              input logic [7:0] b1,
                                              input logic [7:0] b2);
        return b0 ^ b1 ^ b2;
    endfunction

endpackage

// File: rtl/dsi_pkt_fifo.sv
module dsi_pkt_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             push, pop;

    always_comb begin
        push = wr_en && (st_q.cnt != CW'(DEPTH));
        pop  = rd_en && (st_q.cnt != '0);
        st_d = st_q;
        if (push) st_d.wp = st_q.wp + AW'(1);
        if (pop)  st_d.rp = st_q.rp + AW'(1);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[st_q.rp];
    assign count   = st_q.cnt;

endmodule

// File: rtl/dsi_pkt_serializer.sv
module dsi_pkt_serializer
    import dsi_pkt_pkg::*;
#(
    parameter int PCNT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_empty,
    input  logic [HDR_W-1:0]    cmd_head,
    input  logic [WORD_W-1:0]   pld_head,
    input  logic [PCNT_W-1:0]   pld_count,
    output logic                cmd_pop,
    output logic                pld_pop,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_first,
    output logic                tx_last,
    output logic                underflow_err
);
    typedef struct packed {
        pkt_state_e  state;
        logic [7:0]  di;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] left;
        logic [1:0]  idx;
        logic [1:0]  lane;
        logic        err;
    } ser_st_t;

    ser_st_t     st_d, st_q;
    logic [15:0] avail;
    logic [15:0] cnt_req;
    logic        is_long;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        cmd_pop  = 1'b0;
        pld_pop  = 1'b0;
        avail    = 16'({pld_count, 2'b00});
        cnt_req  = cmd_head[23:8];
        is_long  = type_is_long(cmd_head[5:0]);
        case (st_q.state)
            ST_IDLE: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    if (is_long && (cnt_req > avail)) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.state = ST_HDR;
                        st_d.di    = cmd_head[7:0];
                        st_d.lo    = cmd_head[15:8];
                        st_d.hi    = cmd_head[23:16];
                        st_d.left  = is_long ? cnt_req : 16'd0;
                        st_d.idx   = 2'd0;
                        st_d.lane  = 2'd0;
                    end
                end
            end
            ST_HDR: begin
                st_d.idx = st_q.idx + 2'd1;
                if (st_q.idx == 2'd3)
                    st_d.state = (st_q.left != 16'd0) ? ST_PLD : ST_IDLE;
            end
            ST_PLD: begin
                st_d.left = st_q.left - 16'd1;
                st_d.lane = st_q.lane + 2'd1;
                if ((st_q.lane == 2'd3) || (st_q.left == 16'd1)) pld_pop = 1'b1;
                if (st_q.left == 16'd1) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_data = '0;
        if (st_q.state == ST_HDR) begin
            case (st_q.idx)
                2'd0:    tx_data = st_q.di;
                2'd1:    tx_data = st_q.lo;
                2'd2:    tx_data = st_q.hi;
                default: tx_data = check_byte(st_q.di, st_q.lo, st_q.hi);
            endcase
        end else if (st_q.state == ST_PLD) begin
            tx_data = pld_head[{st_q.lane, 3'b000} +: 8];
        end
    end

    assign tx_valid      = (st_q.state != ST_IDLE);
    assign tx_first      = (st_q.state == ST_HDR) && (st_q.idx == 2'd0);
    assign tx_last       = ((st_q.state == ST_HDR) && (st_q.idx == 2'd3) && (st_q.left == 16'd0))
                        || ((st_q.state == ST_PLD) && (st_q.left == 16'd1));
    assign underflow_err = st_q.err;

endmodule

// File: rtl/dsi_cmd_pkt_builder.sv
module dsi_cmd_pkt_builder
    import dsi_pkt_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pld_wr_en,
    input  logic [31:0] pld_wr_data,
    input  logic        hdr_wr_en,
    input  logic [23:0] hdr_wr_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_first,
    output logic        tx_last,
    output logic        cmd_empty,
    output logic        cmd_full,
    output logic        pld_empty,
    output logic        pld_full,
    output logic        underflow_err
);
    localparam int CCNT_W = $clog2(CMD_DEPTH) + 1;
    localparam int PCNT_W = $clog2(PLD_DEPTH) + 1;

    logic [HDR_W-1:0]  cmd_head;
    logic [WORD_W-1:0] pld_head;
    logic [CCNT_W-1:0] cmd_count;
    logic [PCNT_W-1:0] pld_count;
    logic              cmd_pop, pld_pop;

    dsi_pkt_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) cmd_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(hdr_wr_en), .wr_data(hdr_wr_data),
        .rd_en(cmd_pop), .rd_data(cmd_head), .count(cmd_count)
    );

    dsi_pkt_fifo #(.WIDTH(WORD_W), .DEPTH(PLD_DEPTH)) pld_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pld_wr_en), .wr_data(pld_wr_data),
        .rd_en(pld_pop), .rd_data(pld_head), .count(pld_count)
    );

    assign cmd_empty = (cmd_count == '0);
    assign cmd_full  = (cmd_count == CCNT_W'(CMD_DEPTH));
    assign pld_empty = (pld_count == '0);
    assign pld_full  = (pld_count == PCNT_W'(PLD_DEPTH));

    dsi_pkt_serializer #(.PCNT_W(PCNT_W)) ser_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head),
        .pld_head(pld_head), .pld_count(pld_count),
        .cmd_pop(cmd_pop), .pld_pop(pld_pop),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last),
        .underflow_err(underflow_err)
    );

endmodule

// File: rtl/dsi_cmd_pkt_builder_chk.sv
module dsi_cmd_pkt_builder_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_first,
    input logic tx_last,
    input logic cmd_empty,
    input logic cmd_full,
    input logic pld_empty,
    input logic pld_full,
    input logic underflow_err
);
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid);

    a_r8_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        tx_first |-> (tx_valid && !tx_last));

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |=> !tx_valid);

    a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> !tx_valid);

    a_r7_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_empty && cmd_full));

    a_r7_pld_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(pld_empty && pld_full));

endmodule

bind dsi_cmd_pkt_builder dsi_cmd_pkt_builder_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .cmd_empty(cmd_empty), .cmd_full(cmd_full),
    .pld_empty(pld_empty), .pld_full(pld_full),
    .underflow_err(underflow_err)
);

// File: tb/dsi_cmd_pkt_builder_tb_top.sv
module dsi_cmd_pkt_builder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pld_wr_en = 1'b0;
    logic [31:0] pld_wr_data = '0;
    logic        hdr_wr_en = 1'b0;
    logic [23:0] hdr_wr_data = '0;
    logic        tx_valid, tx_first, tx_last;
    logic [7:0]  tx_data;
    logic        cmd_empty, cmd_full, pld_empty, pld_full, underflow_err;

    always #10 clk = ~clk;

    dsi_cmd_pkt_builder dut_i (
        .clk(clk), .rst_n(rst_n),
        .pld_wr_en(pld_wr_en), .pld_wr_data(pld_wr_data),
        .hdr_wr_en(hdr_wr_en), .hdr_wr_data(hdr_wr_data),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last),
        .cmd_empty(cmd_empty), .cmd_full(cmd_full),
        .pld_empty(pld_empty), .pld_full(pld_full),
        .underflow_err(underflow_err)
    );

    // {header[23:0], payload words to push[4:0]}
    localparam int NVEC = 11;
    localparam logic [28:0] VEC_TAB [NVEC] = '{
        {24'h001105, 5'd0},   // short, vc0, one param
        {24'h5AA5E3, 5'd0},   // short, vc3, two params
        {24'h000469, 5'd1},   // long, vc1, 4 bytes
        {24'h0007B9, 5'd2},   // long, vc2, 7 bytes
        {24'h000129, 5'd1},   // long, 1 byte
        {24'h000039, 5'd0},   // long, zero bytes
        {24'h000D29, 5'd4},   // long, 13 bytes
        {24'h000929, 5'd2},   // long, 9 bytes but only 8 queued -> drop
        {24'h000C29, 5'd1},   // long, 12 bytes using retained words
        {24'h003415, 5'd1},   // short while one word waits
        {24'h000429, 5'd0}    // long consuming that word
    };

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seq    = 0;
    int err_seen = 0;
    bit done   = 1'b0;

    logic [7:0]  got_b [$];
    bit          got_f [$];
    bit          got_l [$];
    int          first_cyc [$];
    logic [31:0] mdl_pld [$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                got_b.push_back(tx_data);
                got_f.push_back(tx_first);
                got_l.push_back(tx_last);
                if (tx_first) first_cyc.push_back(cyc);
            end
            if (underflow_err) err_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int n);
        return 32'h9E3779B9 * (n + 1) ^ 32'h0F1E2D3C;
    endfunction

    task automatic push_words(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            pld_wr_en   = 1'b1;
            pld_wr_data = pat(seq);
            seq++;
        end
        @(negedge clk);
        pld_wr_en = 1'b0;
    endtask

    task automatic clear_cap();
        got_b.delete(); got_f.delete(); got_l.delete(); first_cyc.delete();
        err_seen = 0;
    endtask

    task automatic run_vec(input logic [23:0] hdr, input int nw);
        logic [7:0] exp_b [$];
        bit is_long, exp_err, bytes_ok, flags_ok;
        int wc, nwords;
        string tag;
        for (int j = 0; j < nw; j++) mdl_pld.push_back(pat(seq + j));
        push_words(nw);
        is_long = hdr[3];
        wc = int'(hdr[23:8]);
        exp_err = is_long && (wc > 4 * mdl_pld.size());
        tag = exp_err ? "R6" : (is_long ? ((wc == 0) ? "R5" : "R4") : "R3");
        if (!exp_err) begin
            exp_b.push_back(hdr[7:0]);
            exp_b.push_back(hdr[15:8]);
            exp_b.push_back(hdr[23:16]);
            exp_b.push_back(hdr[7:0] ^ hdr[15:8] ^ hdr[23:16]);
            if (is_long) begin
                for (int b = 0; b < wc; b++)
                    exp_b.push_back(8'(mdl_pld[b / 4] >> (8 * (b % 4))));
                nwords = (wc + 3) / 4;
                for (int j = 0; j < nwords; j++) void'(mdl_pld.pop_front());
            end
        end
        clear_cap();
        @(negedge clk);
        hdr_wr_en = 1'b1; hdr_wr_data = hdr;
        @(negedge clk);
        hdr_wr_en = 1'b0;
        repeat (80) @(negedge clk);
        chk(got_b.size() == exp_b.size(), tag, "byte count", got_b.size(), exp_b.size());
        bytes_ok = (got_b.size() == exp_b.size());
        flags_ok = 1'b1;
        for (int i = 0; i < got_b.size() && bytes_ok; i++) begin
            if (got_b[i] !== exp_b[i]) begin
                bytes_ok = 1'b0;
                // R1 R2: header layout and check byte; R4: payload order
                chk(1'b0, (i < 4) ? "R1/R2" : "R4", $sformatf("byte %0d", i), got_b[i], exp_b[i]);
            end
            if (got_f[i] != (i == 0) || got_l[i] != (i == got_b.size() - 1)) flags_ok = 1'b0;
        end
        if (bytes_ok) chk(1'b1, tag, "bytes", 0, 0);
        chk(flags_ok, "R8", "first/last marks", flags_ok, 1);
        chk(err_seen == (exp_err ? 1 : 0), "R6", "error pulses", err_seen, exp_err ? 1 : 0);
        chk(pld_empty == (mdl_pld.size() == 0), tag, "payload left (pld_empty)",
            pld_empty, mdl_pld.size() == 0);
        chk(cmd_empty == 1'b1, tag, "header consumed", cmd_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(tx_valid == 1'b0, "R10", "tx_valid", tx_valid, 0);
        chk(underflow_err == 1'b0, "R10", "underflow_err", underflow_err, 0);
        chk({cmd_empty, pld_empty} == 2'b11, "R10", "empty flags", {cmd_empty, pld_empty}, 3);
        chk({cmd_full, pld_full} == 2'b00, "R7", "full flags", {cmd_full, pld_full}, 0);

        for (int v = 0; v < NVEC; v++)
            run_vec(VEC_TAB[v][28:5], int'(VEC_TAB[v][4:0]));

        // R9 latency and in-order queueing of three short headers
        begin
            int k;
            clear_cap();
            @(negedge clk);
            k = cyc;
            hdr_wr_en = 1'b1; hdr_wr_data = 24'h010203;
            @(negedge clk); hdr_wr_data = 24'h040543;
            @(negedge clk); hdr_wr_data = 24'h060783;
            @(negedge clk); hdr_wr_en = 1'b0;
            repeat (30) @(negedge clk);
            chk(first_cyc.size() == 3, "R9", "packets seen", first_cyc.size(), 3);
            if (first_cyc.size() == 3) begin
                chk(first_cyc[0] == k + 2, "R9", "first byte cycle", first_cyc[0], k + 2);
                chk(first_cyc[1] == k + 7, "R9", "second packet cycle", first_cyc[1], k + 7);
                chk(first_cyc[2] == k + 12, "R9", "third packet cycle", first_cyc[2], k + 12);
            end
            chk(got_b.size() == 12, "R9", "queued byte count", got_b.size(), 12);
            if (got_b.size() == 12) begin
                chk(got_b[4] == 8'h43 && got_b[8] == 8'h83, "R9", "order",
                    {got_b[4], got_b[8]}, 16'h4383);
                chk(got_b[11] == (8'h83 ^ 8'h07 ^ 8'h06), "R2", "check byte",
                    got_b[11], 8'h83 ^ 8'h07 ^ 8'h06);
            end
        end

        // R7 overflow: 17 writes, only 16 kept
        for (int j = 0; j < 16; j++) mdl_pld.push_back(pat(seq + j));
        push_words(17);
        chk(pld_full == 1'b1, "R7", "pld_full", pld_full, 1);
        chk(pld_empty == 1'b0, "R7", "pld_empty when full", pld_empty, 0);
        run_vec(24'h004029, 0);
        chk(pld_full == 1'b0, "R7", "pld_full after drain", pld_full, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule